// File: doc/BRIEF.md
# Quadrature-Fed Up/Down Counter with Two Compare Bounds

This block keeps a W-bit position count that moves one step per cycle from decoded up and down pulses. A one-bit scheme select picks how the count is bounded and cleared. In scheme A, a two-bit clear select can enable an external clear input, a clear when an up step meets compare value 0, or both. An underflow can also reload compare value 0 into the counter. In scheme B, compare value 0 bounds up counting and compare value 1 bounds down counting. Each bound clears the count and raises its own interrupt pulse.

All outputs are registered and change on the clock edge that follows the cycle in which the inputs were presented. The block has no data stream, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure. The pulse decoder sits upstream and delivers at most one step per cycle. Compare values are static configuration inputs.

Top module: `updc_counter`

## Requirements
- R1: Reset (active-low `rst_n`) sets the count to zero and drives all four pulse outputs low. The count width is the parameter W, 16 by default.
- R2: An up step (up=1, dn=0) adds one and a down step (dn=1, up=0) subtracts one. An up step from all-ones wraps to zero and pulses `oflow`. A down step from zero with no reload wraps to all-ones and pulses `uflow`.
- R3: In scheme A (`mode_b`=0), `clr_sel` bit 1 enables the match clear. An up step taken while count equals `cmp0` loads zero instead of incrementing and pulses `irq0`. With bit 1 clear, the same step simply increments.
- R4: In scheme A, `clr_sel` bit 0 enables the external clear. `ext_clr`=1 loads zero on the next edge, overrides any step in that cycle and raises no pulse. With bit 0 clear, `ext_clr` has no effect.
- R5: In scheme A with `reload_en`=1, a down step from zero loads `cmp0` and pulses `uflow`.
- R6: In scheme B (`mode_b`=1), an up step while count equals `cmp0` loads zero and pulses `irq0`. Otherwise an up step increments, including when count equals `cmp1`.
- R7: In scheme B, a down step while count equals `cmp1` loads zero and pulses `irq1`. This takes precedence over underflow. Otherwise a down step decrements, including when count equals `cmp0`. A down step from zero wraps to all-ones.
- R8: In scheme B, `ext_clr`, `clr_sel` and `reload_en` have no effect on count or pulses.
- R9: While `en`=0, the count holds and no pulse is raised, whatever the other inputs are.
- R10: up=1 and dn=1 in the same cycle is no step. The count holds and no pulse is raised, unless a scheme A external clear applies.
- R11: Every pulse output is one clock wide, and at most one of `irq0`, `irq1`, `uflow`, `oflow` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Count enable |
| mode_b | input | 1 | Scheme select: 0 = scheme A, 1 = scheme B |
| clr_sel | input | 2 | Scheme A clear sources: bit 0 external, bit 1 up match on cmp0 |
| reload_en | input | 1 | Scheme A: reload cmp0 on underflow |
| ext_clr | input | 1 | External clear request |
| up | input | 1 | Up step pulse |
| dn | input | 1 | Down step pulse |
| cmp0 | input | W | Compare value 0 |
| cmp1 | input | W | Compare value 1 |
| count | output | W | Current count |
| irq0 | output | 1 | Compare 0 clear pulse |
| irq1 | output | 1 | Compare 1 clear pulse |
| uflow | output | 1 | Underflow pulse |
| oflow | output | 1 | Overflow pulse |

## Verification
The bench builds the counter with W=4, so the whole count range is only sixteen values. At that width, wrap-around in both directions is reached within a few steps. Every pair of count and `cmp0` can be tried against the scheme A match clear. Every pair of `cmp0` and `cmp1` can be walked in scheme B with pseudo-random steps, external clears and reload settings, so both bounds, their coincidence with zero and all-ones, and underflow wrap all occur many times.

// File: rtl/updc_pkg.sv
package updc_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } dir_e;

  localparam int CLR_EXT_BIT   = 0;
  localparam int CLR_MATCH_BIT = 1;
endpackage

// File: rtl/updc_dir.sv
module updc_dir
  import updc_pkg::*;
(
  input  logic en,
  input  logic up,
  input  logic dn,
  output dir_e dir
);
  always_comb begin
    dir = DIR_NONE;
    if (en) begin
      unique case ({up, dn})
        2'b10:   dir = DIR_UP;
        2'b01:   dir = DIR_DN;
        default: dir = DIR_NONE;
      endcase
    end
  end
endmodule

// File: rtl/updc_cmp.sv
module updc_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  output logic         hit0,
  output logic         hit1,
  output logic         at_zero,
  output logic         at_max
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  assign hit0    = (count == cmp0);
  assign hit1    = (count == cmp1);
  assign at_zero = (count == '0);
  assign at_max  = (count == ALL_ONES);
endmodule

// File: rtl/updc_next.sv
module updc_next
  import updc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         en,
  input  logic         mode_b,
  input  logic [1:0]   clr_sel,
  input  logic         reload_en,
  input  logic         ext_clr,
  input  dir_e         dir,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp0,
  input  logic         hit0,
  input  logic         hit1,
  input  logic         at_zero,
  input  logic         at_max,
  output logic [W-1:0] nxt_count,
  output logic         nxt_irq0,
  output logic         nxt_irq1,
  output logic         nxt_uflow,
  output logic         nxt_oflow
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic ext_hit;
  logic up_clear;
  logic dn_clear;
  logic [W-1:0] wrap_low;

  // External clear is honoured only in scheme A and only when selected.
  assign ext_hit  = en && !mode_b && clr_sel[CLR_EXT_BIT] && ext_clr;
  // Up-direction bound: scheme B always, scheme A only when selected.
  assign up_clear = hit0 && (mode_b || clr_sel[CLR_MATCH_BIT]);
  // Down-direction bound exists only in scheme B.
  assign dn_clear = hit1 && mode_b;
  // Value taken on underflow.
  assign wrap_low = (!mode_b && reload_en) ? cmp0 : ALL_ONES;

  always_comb begin
    nxt_count = count;
    nxt_irq0  = 1'b0;
    nxt_irq1  = 1'b0;
    nxt_uflow = 1'b0;
    nxt_oflow = 1'b0;
    if (ext_hit) begin
      nxt_count = '0;
    end else begin
      unique case (dir)
        DIR_UP: begin
          if (up_clear) begin
            nxt_count = '0;
            nxt_irq0  = 1'b1;
          end else begin
            nxt_count = count + ONE;
            nxt_oflow = at_max;
          end
        end
        DIR_DN: begin
          if (dn_clear) begin
            nxt_count = '0;
            nxt_irq1  = 1'b1;
          end else if (at_zero) begin
            nxt_count = wrap_low;
            nxt_uflow = 1'b1;
          end else begin
            nxt_count = count - ONE;
          end
        end
        default: nxt_count = count;
      endcase
    end
  end
endmodule

// File: rtl/updc_counter.sv
module updc_counter
  import updc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         mode_b,
  input  logic [1:0]   clr_sel,
  input  logic         reload_en,
  input  logic         ext_clr,
  input  logic         up,
  input  logic         dn,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  output logic [W-1:0] count,
  output logic         irq0,
  output logic         irq1,
  output logic         uflow,
  output logic         oflow
);
  dir_e         dir;
  logic         hit0, hit1, at_zero, at_max;
  logic [W-1:0] nxt_count;
  logic         nxt_irq0, nxt_irq1, nxt_uflow, nxt_oflow;

  updc_dir u_dir (
    .en  (en),
    .up  (up),
    .dn  (dn),
    .dir (dir)
  );

  updc_cmp #(.W(W)) u_cmp (
    .count   (count),
    .cmp0    (cmp0),
    .cmp1    (cmp1),
    .hit0    (hit0),
    .hit1    (hit1),
    .at_zero (at_zero),
    .at_max  (at_max)
  );

  updc_next #(.W(W)) u_next (
    .en        (en),
    .mode_b    (mode_b),
    .clr_sel   (clr_sel),
    .reload_en (reload_en),
    .ext_clr   (ext_clr),
    .dir       (dir),
    .count     (count),
    .cmp0      (cmp0),
    .hit0      (hit0),
    .hit1      (hit1),
    .at_zero   (at_zero),
    .at_max    (at_max),
    .nxt_count (nxt_count),
    .nxt_irq0  (nxt_irq0),
    .nxt_irq1  (nxt_irq1),
    .nxt_uflow (nxt_uflow),
    .nxt_oflow (nxt_oflow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      irq0  <= 1'b0;
      irq1  <= 1'b0;
      uflow <= 1'b0;
      oflow <= 1'b0;
    end else begin
      count <= nxt_count;
      irq0  <= nxt_irq0;
      irq1  <= nxt_irq1;
      uflow <= nxt_uflow;
      oflow <= nxt_oflow;
    end
  end
endmodule

// File: rtl/updc_checker.sv
module updc_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         mode_b,
  input logic [1:0]   clr_sel,
  input logic         reload_en,
  input logic         ext_clr,
  input logic         up,
  input logic         dn,
  input logic [W-1:0] cmp0,
  input logic [W-1:0] cmp1,
  input logic [W-1:0] count,
  input logic         irq0,
  input logic         irq1,
  input logic         uflow,
  input logic         oflow
);
  logic a_ext;
  assign a_ext = !mode_b && clr_sel[0] && ext_clr;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count) && !irq0 && !irq1 && !uflow && !oflow);

  a_r4_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
    en && a_ext |=> count == '0 && !irq0 && !irq1 && !uflow && !oflow);

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    en && !a_ext && !mode_b && reload_en && dn && !up && count == '0
    |=> uflow && count == $past(cmp0));

  a_r6_b_up_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en && mode_b && up && !dn && count == cmp0 |=> irq0 && count == '0);

  a_r7_b_dn_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en && mode_b && dn && !up && count == cmp1 |=> irq1 && count == '0);

  a_r10_both_steps: assert property (@(posedge clk) disable iff (!rst_n)
    en && up && dn && !a_ext |=> $stable(count) && !irq0 && !irq1 && !uflow && !oflow);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq0, irq1, uflow, oflow}));

  a_r11_irq0_width: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 && !(en && up && !dn && count == '0 && cmp0 == '0 && (mode_b || clr_sel[1]) && !a_ext)
    |=> !irq0);
endmodule

bind updc_counter updc_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .mode_b    (mode_b),
  .clr_sel   (clr_sel),
  .reload_en (reload_en),
  .ext_clr   (ext_clr),
  .up        (up),
  .dn        (dn),
  .cmp0      (cmp0),
  .cmp1      (cmp1),
  .count     (count),
  .irq0      (irq0),
  .irq1      (irq1),
  .uflow     (uflow),
  .oflow     (oflow)
);

// File: tb/updc_counter_bench.sv
module updc_counter_bench;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         mode_b = 1'b0;
  logic [1:0]   clr_sel = 2'b00;
  logic         reload_en = 1'b0;
  logic         ext_clr = 1'b0;
  logic         up = 1'b0;
  logic         dn = 1'b0;
  logic [W-1:0] cmp0 = '0;
  logic [W-1:0] cmp1 = '0;
  logic [W-1:0] count;
  logic         irq0, irq1, uflow, oflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] m_count = '0;
  logic [15:0] lfsr = 16'hACE1;

  updc_counter #(.W(W)) u_updc_counter (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_b(mode_b), .clr_sel(clr_sel),
    .reload_en(reload_en), .ext_clr(ext_clr), .up(up), .dn(dn),
    .cmp0(cmp0), .cmp1(cmp1), .count(count), .irq0(irq0), .irq1(irq1),
    .uflow(uflow), .oflow(oflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One cycle of stimulus; expected values follow the requirements.
  task automatic apply(input logic e, input logic u, input logic d, input logic x,
                       input string tag);
    logic [W-1:0] nx;
    logic ei0, ei1, eu, eo;
    nx = m_count; ei0 = 0; ei1 = 0; eu = 0; eo = 0;
    if (e) begin
      if (!mode_b && clr_sel[0] && x) nx = '0;
      else if (u && !d) begin
        if (m_count == cmp0 && (mode_b || clr_sel[1])) begin nx = '0; ei0 = 1; end
        else begin nx = m_count + 1'b1; eo = (m_count == MAXV); end
      end else if (d && !u) begin
        if (mode_b && m_count == cmp1) begin nx = '0; ei1 = 1; end
        else if (m_count == '0) begin
          eu = 1;
          nx = (!mode_b && reload_en) ? cmp0 : MAXV;
        end else nx = m_count - 1'b1;
      end
    end
    en = e; up = u; dn = d; ext_clr = x;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "count", int'(count), int'(nx));
    chk(tag, "irq0", int'(irq0), int'(ei0));
    chk(tag, "irq1", int'(irq1), int'(ei1));
    chk(tag, "uflow", int'(uflow), int'(eu));
    chk(tag, "oflow", int'(oflow), int'(eo));
    m_count = nx;
    en = 1'b1; up = 1'b0; dn = 1'b0; ext_clr = 1'b0;
  endtask

  task automatic reach(input int v);
    mode_b = 1'b0; clr_sel = 2'b01; reload_en = 1'b0;
    apply(1, 0, 0, 1, "R4");
    for (int i = 0; i < v; i++) apply(1, 1, 0, 0, "R2");
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "count", int'(count), 0);
    chk("R1", "pulses", int'({irq0, irq1, uflow, oflow}), 0);

    // R2 up wrap with overflow, then down wrap with underflow
    mode_b = 0; clr_sel = 2'b00; reload_en = 0;
    for (int i = 0; i < 20; i++) apply(1, 1, 0, 0, "R2");
    reach(0);
    for (int i = 0; i < 20; i++) apply(1, 0, 1, 0, "R2");

    // R3 match clear swept over every cmp0 and start value, both settings of bit 1
    for (int c = 0; c < 16; c++) begin
      for (int v = 0; v < 16; v++) begin
        reach(v);
        cmp0 = c[W-1:0];
        clr_sel = (v[0]) ? 2'b10 : 2'b00;
        apply(1, 1, 0, 0, "R3");
      end
    end

    // R4 external clear with each clr_sel, competing with a step
    for (int s = 0; s < 4; s++) begin
      reach(5);
      clr_sel = s[1:0]; cmp0 = 4'd9;
      apply(1, 1, 0, 1, "R4");
      reach(5);
      clr_sel = s[1:0];
      apply(1, 0, 1, 1, "R4");
    end

    // R5 reload on underflow for every cmp0; without reload wraps
    for (int c = 0; c < 16; c++) begin
      reach(0);
      cmp0 = c[W-1:0]; clr_sel = 2'b00; reload_en = 1'b1;
      apply(1, 0, 1, 0, "R5");
      reload_en = 1'b0;
      reach(0);
      clr_sel = 2'b00;
      apply(1, 0, 1, 0, "R2");
    end

    // R9 enable low holds under every stimulus
    reach(7);
    clr_sel = 2'b11; cmp0 = 4'd7; mode_b = 1'b0;
    apply(0, 1, 0, 1, "R9");
    apply(0, 0, 1, 0, "R9");
    mode_b = 1'b1; cmp1 = 4'd7;
    apply(0, 0, 1, 0, "R9");
    apply(0, 1, 0, 0, "R9");

    // R10 simultaneous up and down
    reach(3);
    clr_sel = 2'b10; cmp0 = 4'd3;
    apply(1, 1, 1, 0, "R10");
    mode_b = 1'b1; cmp1 = 4'd3;
    apply(1, 1, 1, 1, "R10");

    // R6 R7 R8 scheme B walks over every cmp0/cmp1 pair
    mode_b = 1'b1;
    for (int c0 = 0; c0 < 16; c0++) begin
      for (int c1 = 0; c1 < 16; c1++) begin
        cmp0 = c0[W-1:0]; cmp1 = c1[W-1:0];
        for (int k = 0; k < 40; k++) begin
          logic u, x;
          step_lfsr();
          u = lfsr[0];
          x = lfsr[3] & lfsr[5];
          clr_sel = lfsr[7:6];
          reload_en = lfsr[9];
          if (x) apply(1, u, !u, 1, "R8");
          else if (u) apply(1, 1, 0, 0, "R6");
          else apply(1, 0, 1, 0, "R7");
        end
      end
    end

    // R11 pulses drop after one cycle of idle
    mode_b = 1'b0; clr_sel = 2'b00;
    reach(15);
    clr_sel = 2'b00;
    apply(1, 1, 0, 0, "R11");
    apply(1, 0, 0, 0, "R11");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule